// File: doc/BRIEF.md
# Cascaded Secondary Interrupt Controller

This block gathers a bank of level-sensitive interrupt sources for a downstream primary interrupt controller that has only a few free inputs. Each source can be individually enabled. All enabled sources that are not marked for direct routing are combined into one cascade request, which is wired to line 31 of the primary controller. Software services that line by reading a masked status word and then handling each pending bit.

Upper sources can also be routed directly to the primary controller input with the same number. Each of these sources has its own bypass bit, and setting it removes the source from the cascade request. Sources are not latched. Every output and the status word follow the live input levels through the enable and bypass masks.

Software uses a small register port. Writes take one cycle. Reads return data one cycle after they are requested. Enable bits are changed only through separate set and clear addresses, so two agents can change different sources without a read-modify-write.

Top module: `sic_cascade_ctrl`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) clears every enable bit and every bypass bit, drives `rd_data` to 0, and leaves `cascade_irq` and `bypass_irq` low.
- R2: A write to address 1 (enable-set) sets each enable bit whose `wr_data` bit is 1. Enable bits whose `wr_data` bit is 0 keep their value. The change is visible from the next cycle on.
- R3: A write to address 2 (enable-clear) clears each enable bit whose `wr_data` bit is 1, and keeps the others. Writing all ones disables every source.
- R4: A read of address 0 (status) returns `src_irq & enable` as sampled at the request edge, on `rd_data` one cycle after `rd_en`. Nothing is latched, so a source that drops disappears from the next status read.
- R5: `cascade_irq` is high exactly when some source is pending, enabled and has its bypass bit clear.
- R6: For a source at index 21 or above, `bypass_irq[i]` equals `src_irq[i]` when its bypass bit is set, whether or not the source is enabled. Otherwise `bypass_irq[i]` is 0.
- R7: The bypass register (address 3, read/write) holds bits 21 and up. Bits below 21 read zero and ignore writes, so writing 0xFFD00000 reads back 0xFFC00000.
- R8: A read at address 1 returns the enable mask. A read at address 2 returns 0. Writes to address 0 change no state. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | 32 | Level-sensitive interrupt sources |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 status, 1 set, 2 clear, 3 bypass) |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| cascade_irq | output | 1 | Combined request for primary input 31 |
| bypass_irq | output | 32 | Direct request lines for primary inputs of the same number |

## Verification
A status read can fall in the same cycle as an enable-set write. The bench issues both in one cycle with the source already high. It then expects the read to return the old, empty status while `cascade_irq` rises at that same edge, and it expects a status read in the following cycle to show the bit. A bypass write can also fall while its source is pending. The bench judges that case by seeing the request move from `cascade_irq` to the matching `bypass_irq` line at the write edge, with no cycle in which both lines are high or both are low.

// File: rtl/sic_pkg.sv
package sic_pkg;
   typedef enum logic [1:0] {
      SIC_STATUS = 2'd0,
      SIC_EN_SET = 2'd1,
      SIC_EN_CLR = 2'd2,
      SIC_BYPASS = 2'd3
   } sic_reg_e;
endpackage

// File: rtl/sic_mask_regs.sv
module sic_mask_regs #(
   parameter int NSRC     = 32,
   parameter int PASS_LSB = 21
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [1:0]      wr_addr,
   input  logic [NSRC-1:0] wr_data,
   output logic [NSRC-1:0] en_q,
   output logic [NSRC-1:0] pass_q
);
   import sic_pkg::*;

   logic set_hit, clr_hit, pass_hit;
   assign set_hit  = wr_en && (wr_addr == SIC_EN_SET);
   assign clr_hit  = wr_en && (wr_addr == SIC_EN_CLR);
   assign pass_hit = wr_en && (wr_addr == SIC_BYPASS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= '0;
      else if (set_hit)
         en_q <= en_q | wr_data;
      else if (clr_hit)
         en_q <= en_q & ~wr_data;
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_pass
      if (i >= PASS_LSB) begin : g_cap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pass_q[i] <= 1'b0;
            else if (pass_hit)
               pass_q[i] <= wr_data[i];
         end
      end else begin : g_fixed
         assign pass_q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/sic_route.sv
module sic_route #(
   parameter int NSRC     = 32,
   parameter int PASS_LSB = 21
) (
   input  logic [NSRC-1:0] src_irq,
   input  logic [NSRC-1:0] en_q,
   input  logic [NSRC-1:0] pass_q,
   output logic [NSRC-1:0] status,
   output logic            cascade_irq,
   output logic [NSRC-1:0] bypass_irq
);
   logic [NSRC-1:0] contrib;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign status[i] = src_irq[i] & en_q[i];
      if (i >= PASS_LSB) begin : g_cap
         assign contrib[i]    = src_irq[i] & en_q[i] & ~pass_q[i];
         assign bypass_irq[i] = src_irq[i] & pass_q[i];
      end else begin : g_plain
         assign contrib[i]    = src_irq[i] & en_q[i];
         assign bypass_irq[i] = 1'b0;
      end
   end

   assign cascade_irq = |contrib;
endmodule

// File: rtl/sic_rd_port.sv
module sic_rd_port #(
   parameter int NSRC = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd_en,
   input  logic [1:0]      rd_addr,
   input  logic [NSRC-1:0] status,
   input  logic [NSRC-1:0] en_q,
   input  logic [NSRC-1:0] pass_q,
   output logic [NSRC-1:0] rd_data
);
   import sic_pkg::*;

   logic [NSRC-1:0] rd_mux;

   always_comb begin
      unique case (sic_reg_e'(rd_addr))
         SIC_STATUS: rd_mux = status;
         SIC_EN_SET: rd_mux = en_q;
         SIC_EN_CLR: rd_mux = '0;
         SIC_BYPASS: rd_mux = pass_q;
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (rd_en)
         rd_data <= rd_mux;
   end
endmodule

// File: rtl/sic_cascade_ctrl.sv
module sic_cascade_ctrl #(
   parameter int NSRC     = 32,
   parameter int PASS_LSB = 21
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_irq,
   input  logic            wr_en,
   input  logic [1:0]      wr_addr,
   input  logic [NSRC-1:0] wr_data,
   input  logic            rd_en,
   input  logic [1:0]      rd_addr,
   output logic [NSRC-1:0] rd_data,
   output logic            cascade_irq,
   output logic [NSRC-1:0] bypass_irq
);
   if (NSRC < 1 || NSRC > 32) begin : g_bad_nsrc
      $error("sic_cascade_ctrl: NSRC must lie in 1..32");
   end
   if (PASS_LSB < 0 || PASS_LSB > NSRC) begin : g_bad_lsb
      $error("sic_cascade_ctrl: PASS_LSB must lie in 0..NSRC");
   end

   logic [NSRC-1:0] en_q;
   logic [NSRC-1:0] pass_q;
   logic [NSRC-1:0] status;

   sic_mask_regs #(.NSRC(NSRC), .PASS_LSB(PASS_LSB)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .en_q    (en_q),
      .pass_q  (pass_q)
   );

   sic_route #(.NSRC(NSRC), .PASS_LSB(PASS_LSB)) u_route (
      .src_irq     (src_irq),
      .en_q        (en_q),
      .pass_q      (pass_q),
      .status      (status),
      .cascade_irq (cascade_irq),
      .bypass_irq  (bypass_irq)
   );

   sic_rd_port #(.NSRC(NSRC)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .status  (status),
      .en_q    (en_q),
      .pass_q  (pass_q),
      .rd_data (rd_data)
   );
endmodule

// File: rtl/sic_cascade_chk.sv
module sic_cascade_chk #(
   parameter int NSRC     = 32,
   parameter int PASS_LSB = 21
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NSRC-1:0] src_irq,
   input logic            wr_en,
   input logic [1:0]      wr_addr,
   input logic [NSRC-1:0] wr_data,
   input logic            rd_en,
   input logic [1:0]      rd_addr,
   input logic [NSRC-1:0] rd_data,
   input logic            cascade_irq,
   input logic [NSRC-1:0] bypass_irq,
   input logic [NSRC-1:0] en_q,
   input logic [NSRC-1:0] pass_q
);
   logic was_rst;
   always_ff @(posedge clk) was_rst <= !rst_n;

   always_ff @(posedge clk) begin
      if (rst_n && was_rst) begin
         assert_reset_clean_R1: assert (en_q == '0 && pass_q == '0 && rd_data == '0);
      end
   end

   assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd1) |=> ((en_q & $past(wr_data)) == $past(wr_data)));

   assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd2) |=> ((en_q & $past(wr_data)) == '0));

   assert_status_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == 2'd0) |=> (rd_data == $past(src_irq & en_q)));

   assert_cascade_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cascade_irq == (|(src_irq & en_q & ~pass_q)));

   assert_bypass_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bypass_irq & ~(src_irq & pass_q)) == '0);

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || wr_addr == 2'd0) |=> ($stable(en_q) && $stable(pass_q)));
endmodule

bind sic_cascade_ctrl sic_cascade_chk #(.NSRC(NSRC), .PASS_LSB(PASS_LSB)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .src_irq     (src_irq),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .rd_en       (rd_en),
   .rd_addr     (rd_addr),
   .rd_data     (rd_data),
   .cascade_irq (cascade_irq),
   .bypass_irq  (bypass_irq),
   .en_q        (en_q),
   .pass_q      (pass_q)
);

// File: tb/sim_sic_cascade_ctrl.sv
module sim_sic_cascade_ctrl;
   localparam int N = 32;

   typedef struct packed {
      logic [1:0]  op;      // 0 idle, 1 write, 2 read
      logic [1:0]  addr;
      logic [31:0] wdata;
      logic [31:0] src;
      logic [31:0] exp_rd;
      logic        exp_casc;
      logic [31:0] exp_byp;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 2'd0, 32'h0,        32'h0,        32'h0,        1'b0, 32'h0},
      '{2'd1, 2'd1, 32'h000000F0, 32'h00000010, 32'h0,        1'b1, 32'h0},
      '{2'd2, 2'd0, 32'h0,        32'h00000110, 32'h00000010, 1'b1, 32'h0},
      '{2'd1, 2'd1, 32'h00000100, 32'h00000100, 32'h0,        1'b1, 32'h0},
      '{2'd2, 2'd1, 32'h0,        32'h0,        32'h000001F0, 1'b0, 32'h0},
      '{2'd1, 2'd2, 32'h00000030, 32'h00000020, 32'h0,        1'b0, 32'h0},
      '{2'd2, 2'd1, 32'h0,        32'h00000040, 32'h000001C0, 1'b1, 32'h0},
      '{2'd1, 2'd3, 32'hFFD00000, 32'h0,        32'h0,        1'b0, 32'h0},
      '{2'd2, 2'd3, 32'h0,        32'h0,        32'hFFC00000, 1'b0, 32'h0},
      '{2'd0, 2'd0, 32'h0,        32'h80400000, 32'h0,        1'b0, 32'h80400000},
      '{2'd1, 2'd1, 32'h80100000, 32'h80100000, 32'h0,        1'b1, 32'h80000000},
      '{2'd2, 2'd0, 32'h0,        32'h80100000, 32'h80100000, 1'b1, 32'h80000000},
      '{2'd1, 2'd2, 32'hFFFFFFFF, 32'h80100040, 32'h0,        1'b0, 32'h80000000},
      '{2'd2, 2'd1, 32'h0,        32'h0,        32'h0,        1'b0, 32'h0},
      '{2'd1, 2'd0, 32'hFFFFFFFF, 32'h0,        32'h0,        1'b0, 32'h0},
      '{2'd2, 2'd1, 32'h0,        32'h0,        32'h0,        1'b0, 32'h0},
      '{2'd2, 2'd2, 32'h0,        32'h0,        32'h0,        1'b0, 32'h0},
      '{2'd1, 2'd3, 32'h0,        32'h80000000, 32'h0,        1'b0, 32'h0}
   };

   // Requirement tag for each table row
   localparam string VTAG [NV] = '{"R1","R2","R4","R2","R8","R3","R3","R7","R7",
                                   "R6","R5","R4","R3","R3","R8","R8","R8","R6"};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  src_irq = '0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = '0;
   logic [N-1:0]  wr_data = '0;
   logic          rd_en = 1'b0;
   logic [1:0]    rd_addr = '0;
   logic [N-1:0]  rd_data;
   logic          cascade_irq;
   logic [N-1:0]  bypass_irq;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   sic_cascade_ctrl #(.NSRC(N), .PASS_LSB(21)) u0 (
      .clk(clk), .rst_n(rst_n), .src_irq(src_irq),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .cascade_irq(cascade_irq), .bypass_irq(bypass_irq)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   // One cycle: drive at negedge, sample just after the following posedge
   task automatic step(input logic we, input logic [1:0] wa, input logic [31:0] wd,
                       input logic re, input logic [1:0] ra, input logic [31:0] s);
      @(negedge clk);
      wr_en = we; wr_addr = wa; wr_data = wd;
      rd_en = re; rd_addr = ra; src_irq = s;
      @(posedge clk);
      #1;
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "rd_data in reset", rd_data, 32'h0);
      chk("R1", "cascade in reset", {31'h0, cascade_irq}, 32'h0);
      @(negedge clk) rst_n = 1'b1;
      step(1'b0, 2'd0, 32'h0, 1'b1, 2'd1, 32'hFFFFFFFF);
      chk("R1", "enable after reset", rd_data, 32'h0);
      chk("R1", "cascade after reset", {31'h0, cascade_irq}, 32'h0);
      step(1'b0, 2'd0, 32'h0, 1'b1, 2'd3, 32'h0);
      chk("R1", "bypass reg after reset", rd_data, 32'h0);

      // Vector table
      for (int v = 0; v < NV; v++) begin
         step(VECS[v].op == 2'd1, VECS[v].addr, VECS[v].wdata,
              VECS[v].op == 2'd2, VECS[v].addr, VECS[v].src);
         if (VECS[v].op == 2'd2) chk(VTAG[v], "rd_data", rd_data, VECS[v].exp_rd);
         chk(VTAG[v], "cascade", {31'h0, cascade_irq}, {31'h0, VECS[v].exp_casc});
         chk(VTAG[v], "bypass", bypass_irq, VECS[v].exp_byp);
      end

      // R8: concurrent status read and enable-set write return the old view
      step(1'b1, 2'd1, 32'h00000001, 1'b1, 2'd0, 32'h00000001);
      chk("R8", "status read during set", rd_data, 32'h0);
      chk("R5", "cascade at set edge", {31'h0, cascade_irq}, 32'h1);
      step(1'b0, 2'd0, 32'h0, 1'b1, 2'd0, 32'h00000001);
      chk("R4", "status after set", rd_data, 32'h00000001);
      // R4: no latching
      step(1'b0, 2'd0, 32'h0, 1'b1, 2'd0, 32'h0);
      chk("R4", "status after source drop", rd_data, 32'h0);
      chk("R5", "cascade after source drop", {31'h0, cascade_irq}, 32'h0);

      // R6: request moves from cascade to bypass line at the write edge
      step(1'b1, 2'd1, 32'h02000000, 1'b0, 2'd0, 32'h02000000);
      chk("R5", "cascade before bypass", {31'h0, cascade_irq}, 32'h1);
      chk("R6", "bypass before bypass", bypass_irq, 32'h0);
      step(1'b1, 2'd3, 32'h02000000, 1'b0, 2'd0, 32'h02000000);
      chk("R6", "cascade after bypass", {31'h0, cascade_irq}, 32'h0);
      chk("R6", "bypass after bypass", bypass_irq, 32'h02000000);

      // R1: reset mid-run clears state
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      step(1'b0, 2'd0, 32'h0, 1'b1, 2'd1, 32'h02000000);
      chk("R1", "enable after re-reset", rd_data, 32'h0);
      chk("R1", "bypass line after re-reset", bypass_irq, 32'h0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule